// File: doc/BRIEF.md
# Retirement Trace Lockstep Comparator

The comparator checks that two executions of the same program produce the same sequence of register write-backs. One input port carries write-back events from a reference model and the other carries them from the design under test. The two sources may retire at any relative pace. Each side's events go into a queue of their own. Whenever both queues hold at least one event, the oldest entry of each is removed and the two are compared. In this way the Nth write of one side is always judged against the Nth write of the other, however far apart in time they arrive.

A pair matches when both the destination register index and the data agree. Matches are counted on a 32-bit progress counter. On the first pair that differs, the block records the pair's position in the sequence, both indices and both data values. It then raises a sticky mismatch flag and a halt output. If an event arrives while its side's queue is already full, the block raises a separate sticky overflow flag and halts, so that no event is lost without notice.

The control is a three-state machine:
- `ST_RUN` is the only state that accepts and compares events.
- `ST_RUN` moves to `ST_OVERFLOW` on the "queue overrun" transition.
- `ST_RUN` moves to `ST_MISMATCH` on the "pair differs" transition.
- Both halted states are terminal and are left only through reset.

Top module: `trace_lockstep_cmp`

## Requirements
- R1: After reset `halt`, `mismatch` and `overflow` are 0 and `match_cnt` is 0.
- R2: An event whose register index is 0 is discarded on either side. It never takes a place in the sequence and never affects any output.
- R3: Events accepted on each side are compared strictly in arrival order, the Nth against the Nth, whatever the skew between the sides. A pair with equal index and equal data raises `match_cnt` by one at the first clock edge where both entries are buffered. An event presented in cycle k is buffered at the edge ending cycle k, so it is counted at the following edge at the earliest. `match_cnt` never rises by more than one per cycle.
- R4: A pair differing in index or data sets `mismatch` and `halt`. The same edge captures four values: `fail_seq`, which equals the number of pairs matched before the failing pair, starting at 0; the index and data from the reference side; and the index and data from the design side.
- R5: Once `halt` is 1, inputs are ignored and no further pairs are compared. `match_cnt`, the flags and the captured details hold their values until reset.
- R6: A non-zero-index event arriving while its side already holds DEPTH buffered entries sets `overflow` and `halt`. Overflow takes precedence over a mismatch judged at the same edge, and `mismatch` and `overflow` are never 1 together.
- R7: Either side may run up to DEPTH events ahead of the other without any error.
- R8: Reset clears a halted state, both sticky flags and the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_vld | input | 1 | Reference write-back event valid |
| ref_idx | input | IDX_W | Reference destination register index |
| ref_data | input | DATA_W | Reference written value |
| dut_vld | input | 1 | Design-under-test write-back event valid |
| dut_idx | input | IDX_W | Design-under-test destination register index |
| dut_data | input | DATA_W | Design-under-test written value |
| halt | output | 1 | Stop request; set by any error |
| mismatch | output | 1 | Sticky: a compared pair differed |
| overflow | output | 1 | Sticky: an event arrived at a full queue |
| fail_seq | output | CNT_W | Sequence position of the failing pair |
| fail_ref_idx | output | IDX_W | Reference index of the failing pair |
| fail_ref_data | output | DATA_W | Reference data of the failing pair |
| fail_dut_idx | output | IDX_W | Design index of the failing pair |
| fail_dut_data | output | DATA_W | Design data of the failing pair |
| match_cnt | output | CNT_W | Number of matched pairs |

## Verification
The assertions assume that the inputs are driven by a synchronous source whose valid and payload signals are settled at each rising edge. They also assume that reset is applied before the first event. They take no account of event ordering, because any mix of events must leave the block in a legal state. The stimulus changes inputs only on falling edges. It holds reset for two edges and keeps every scenario within the range the comparator handles: skews below and at DEPTH, runs that exceed DEPTH on purpose, index-0 writes, and differing pairs. Each halted scenario is followed by a reset.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_MISMATCH = 2'd1,
        ST_OVERFLOW = 2'd2
    } trc_state_e;
endpackage

// File: rtl/trc_fifo.sv
module trc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 37
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == FULLV);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/trc_cmp_fsm.sv
module trc_cmp_fsm
    import trc_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_avail,
    input  logic              dut_avail,
    input  logic [IDX_W-1:0]  ref_head_idx,
    input  logic [DATA_W-1:0] ref_head_data,
    input  logic [IDX_W-1:0]  dut_head_idx,
    input  logic [DATA_W-1:0] dut_head_data,
    input  logic              ovf_hit,
    output logic              pop,
    output logic              halt,
    output logic              mismatch,
    output logic              overflow,
    output logic [CNT_W-1:0]  fail_seq,
    output logic [IDX_W-1:0]  fail_ref_idx,
    output logic [DATA_W-1:0] fail_ref_data,
    output logic [IDX_W-1:0]  fail_dut_idx,
    output logic [DATA_W-1:0] fail_dut_data,
    output logic [CNT_W-1:0]  match_cnt
);
    trc_state_e state, nxt;
    logic differ, cnt_inc, capture;

    assign differ = (ref_head_idx != dut_head_idx) || (ref_head_data != dut_head_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt     = state;
        pop     = 1'b0;
        cnt_inc = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_RUN: begin
                pop = ref_avail && dut_avail;
                if (ovf_hit) begin
                    nxt = ST_OVERFLOW;
                end else if (pop && differ) begin
                    nxt     = ST_MISMATCH;
                    capture = 1'b1;
                end else if (pop) begin
                    cnt_inc = 1'b1;
                end
            end
            ST_MISMATCH: nxt = ST_MISMATCH;
            ST_OVERFLOW: nxt = ST_OVERFLOW;
            default:     nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_cnt     <= '0;
            fail_seq      <= '0;
            fail_ref_idx  <= '0;
            fail_ref_data <= '0;
            fail_dut_idx  <= '0;
            fail_dut_data <= '0;
        end else begin
            if (cnt_inc) begin
                match_cnt <= match_cnt + 1'b1;
            end
            if (capture) begin
                fail_seq      <= match_cnt;
                fail_ref_idx  <= ref_head_idx;
                fail_ref_data <= ref_head_data;
                fail_dut_idx  <= dut_head_idx;
                fail_dut_data <= dut_head_data;
            end
        end
    end

    assign halt     = (state != ST_RUN);
    assign mismatch = (state == ST_MISMATCH);
    assign overflow = (state == ST_OVERFLOW);
endmodule

// File: rtl/trace_lockstep_cmp.sv
module trace_lockstep_cmp #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_vld,
    input  logic [IDX_W-1:0]  ref_idx,
    input  logic [DATA_W-1:0] ref_data,
    input  logic              dut_vld,
    input  logic [IDX_W-1:0]  dut_idx,
    input  logic [DATA_W-1:0] dut_data,
    output logic              halt,
    output logic              mismatch,
    output logic              overflow,
    output logic [CNT_W-1:0]  fail_seq,
    output logic [IDX_W-1:0]  fail_ref_idx,
    output logic [DATA_W-1:0] fail_ref_data,
    output logic [IDX_W-1:0]  fail_dut_idx,
    output logic [DATA_W-1:0] fail_dut_data,
    output logic [CNT_W-1:0]  match_cnt
);
    localparam int EW = IDX_W + DATA_W;

    logic          ref_push, dut_push, pop;
    logic          ref_empty, dut_empty, ref_full, dut_full;
    logic [EW-1:0] ref_head, dut_head;
    logic          ovf_hit;

    assign ref_push = ref_vld && (ref_idx != '0) && !halt;
    assign dut_push = dut_vld && (dut_idx != '0) && !halt;
    assign ovf_hit  = (ref_push && ref_full) || (dut_push && dut_full);

    trc_fifo #(.DEPTH(DEPTH), .W(EW)) u_ref_q (
        .clk(clk), .rst_n(rst_n), .push(ref_push), .wdata({ref_idx, ref_data}),
        .pop(pop), .rdata(ref_head), .empty(ref_empty), .full(ref_full)
    );

    trc_fifo #(.DEPTH(DEPTH), .W(EW)) u_dut_q (
        .clk(clk), .rst_n(rst_n), .push(dut_push), .wdata({dut_idx, dut_data}),
        .pop(pop), .rdata(dut_head), .empty(dut_empty), .full(dut_full)
    );

    trc_cmp_fsm #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ref_avail(!ref_empty), .dut_avail(!dut_empty),
        .ref_head_idx(ref_head[EW-1:DATA_W]), .ref_head_data(ref_head[DATA_W-1:0]),
        .dut_head_idx(dut_head[EW-1:DATA_W]), .dut_head_data(dut_head[DATA_W-1:0]),
        .ovf_hit(ovf_hit), .pop(pop),
        .halt(halt), .mismatch(mismatch), .overflow(overflow),
        .fail_seq(fail_seq),
        .fail_ref_idx(fail_ref_idx), .fail_ref_data(fail_ref_data),
        .fail_dut_idx(fail_dut_idx), .fail_dut_data(fail_dut_data),
        .match_cnt(match_cnt)
    );
endmodule

// File: rtl/trace_lockstep_cmp_chk.sv
module trace_lockstep_cmp_chk #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              mismatch,
    input logic              overflow,
    input logic [CNT_W-1:0]  fail_seq,
    input logic [IDX_W-1:0]  fail_ref_idx,
    input logic [DATA_W-1:0] fail_ref_data,
    input logic [IDX_W-1:0]  fail_dut_idx,
    input logic [DATA_W-1:0] fail_dut_data,
    input logic [CNT_W-1:0]  match_cnt
);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_cnt == $past(match_cnt)) || (match_cnt == $past(match_cnt) + 1'b1));

    // R4
    mismatch_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> halt);

    // R4
    detail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> ($stable(fail_seq) && $stable(fail_ref_idx) && $stable(fail_ref_data)
                      && $stable(fail_dut_idx) && $stable(fail_dut_data)));

    // R4
    seq_at_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> (fail_seq == match_cnt));

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R5
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(match_cnt));

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mismatch, overflow}));

    // R6
    overflow_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> halt);
endmodule

bind trace_lockstep_cmp trace_lockstep_cmp_chk #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .halt(halt), .mismatch(mismatch), .overflow(overflow),
    .fail_seq(fail_seq), .fail_ref_idx(fail_ref_idx), .fail_ref_data(fail_ref_data),
    .fail_dut_idx(fail_dut_idx), .fail_dut_data(fail_dut_data), .match_cnt(match_cnt)
);

// File: tb/sim_trace_lockstep_cmp.sv
module sim_trace_lockstep_cmp;
    localparam int PERIOD = 10;
    localparam int D      = 8;
    localparam int LIMIT  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_vld = 1'b0, dut_vld = 1'b0;
    logic [4:0]  ref_idx = '0, dut_idx = '0;
    logic [31:0] ref_data = '0, dut_data = '0;
    logic        halt, mismatch, overflow;
    logic [31:0] fail_seq, fail_ref_data, fail_dut_data, match_cnt;
    logic [4:0]  fail_ref_idx, fail_dut_idx;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    trace_lockstep_cmp #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ref_vld(ref_vld), .ref_idx(ref_idx), .ref_data(ref_data),
        .dut_vld(dut_vld), .dut_idx(dut_idx), .dut_data(dut_data),
        .halt(halt), .mismatch(mismatch), .overflow(overflow),
        .fail_seq(fail_seq), .fail_ref_idx(fail_ref_idx), .fail_ref_data(fail_ref_data),
        .fail_dut_idx(fail_dut_idx), .fail_dut_data(fail_dut_data), .match_cnt(match_cnt)
    );

    // behavioural reference: 0 run, 1 mismatch, 2 overflow
    logic [36:0] refq[$];
    logic [36:0] dutq[$];
    int          m_state = 0;
    logic [31:0] m_cnt = 0, m_seq = 0, m_rd = 0, m_dd = 0;
    logic [4:0]  m_ri = 0, m_di = 0;
    logic [36:0] hr, hd;
    int          rsz, dsz;
    bit          rp, dp, ovf, comp;

    always @(posedge clk) begin
        if (!rst_n) begin
            refq.delete(); dutq.delete();
            m_state = 0; m_cnt = 0; m_seq = 0;
            m_ri = 0; m_di = 0; m_rd = 0; m_dd = 0;
        end else if (m_state == 0) begin
            rp   = ref_vld && (ref_idx != 0);
            dp   = dut_vld && (dut_idx != 0);
            rsz  = refq.size();
            dsz  = dutq.size();
            ovf  = (rp && rsz == D) || (dp && dsz == D);
            comp = (rsz > 0) && (dsz > 0);
            hr = '0; hd = '0;
            if (comp) begin
                hr = refq.pop_front();
                hd = dutq.pop_front();
            end
            if (ovf) m_state = 2;
            else if (comp && hr != hd) begin
                m_state = 1; m_seq = m_cnt;
                m_ri = hr[36:32]; m_rd = hr[31:0];
                m_di = hd[36:32]; m_dd = hd[31:0];
            end else if (comp) m_cnt = m_cnt + 1;
            if (rp && rsz < D) refq.push_back({ref_idx, ref_data});
            if (dp && dsz < D) dutq.push_back({dut_idx, dut_data});
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, a quarter period after the edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (rst_n && !finished) begin
            chk(halt == (m_state != 0), "R5 halt", 32'(halt), 32'(m_state != 0));
            chk(mismatch == (m_state == 1), "R4 mismatch", 32'(mismatch), 32'(m_state == 1));
            chk(overflow == (m_state == 2), "R6 overflow", 32'(overflow), 32'(m_state == 2));
            chk(match_cnt == m_cnt, "R3 match_cnt", match_cnt, m_cnt);
            if (m_state == 1) begin
                chk(fail_seq == m_seq, "R4 fail_seq", fail_seq, m_seq);
                chk(fail_ref_idx == m_ri, "R4 fail_ref_idx", 32'(fail_ref_idx), 32'(m_ri));
                chk(fail_dut_idx == m_di, "R4 fail_dut_idx", 32'(fail_dut_idx), 32'(m_di));
                chk(fail_ref_data == m_rd, "R4 fail_ref_data", fail_ref_data, m_rd);
                chk(fail_dut_data == m_dd, "R4 fail_dut_data", fail_dut_data, m_dd);
            end
        end
    end

    task automatic step(input bit rv, input logic [4:0] ri, input logic [31:0] rd,
                        input bit dv, input logic [4:0] di, input logic [31:0] dd);
        @(negedge clk);
        ref_vld = rv; ref_idx = ri; ref_data = rd;
        dut_vld = dv; dut_idx = di; dut_data = dd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_vld = 0; dut_vld = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
            finish_run();
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1
        chk(!halt && !mismatch && !overflow, "R1 flags", {29'd0, halt, mismatch, overflow}, 0);
        chk(match_cnt == 0, "R1 match_cnt", match_cnt, 0);

        // R3 lockstep pairs
        for (int i = 0; i < 5; i++) step(1, 5'(i + 1), 32'h100 + i, 1, 5'(i + 1), 32'h100 + i);
        idle(3);
        chk(match_cnt == 5, "R3 lockstep", match_cnt, 5);

        // R3 skewed: reference runs ahead, design trickles in
        for (int i = 0; i < 6; i++) step(1, 5'(i + 7), 32'hA000 + i, 0, 0, 0);
        idle(3);
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 0, 1, 5'(i + 7), 32'hA000 + i);
            idle(2);
        end
        idle(2);
        chk(match_cnt == 11 && !halt, "R3 skew", match_cnt, 11);

        // R2 index-0 writes on both sides with unequal data
        step(1, 0, 32'hDEAD, 1, 3, 32'h33);
        step(1, 3, 32'h33, 1, 0, 32'hBEEF);
        step(1, 0, 32'h1, 0, 0, 0);
        step(1, 4, 32'h44, 1, 4, 32'h44);
        step(0, 0, 0, 1, 0, 32'h7);
        step(1, 9, 32'h99, 1, 9, 32'h99);
        idle(3);
        chk(match_cnt == 14 && !halt, "R2 x0 dropped", match_cnt, 14);

        // R7 design side exactly DEPTH ahead
        for (int i = 0; i < D; i++) step(0, 0, 0, 1, 5'(i + 1), 32'h5000 + i);
        idle(2);
        chk(!overflow && !halt, "R7 no overflow at depth", 32'(overflow), 0);
        for (int i = 0; i < D; i++) step(1, 5'(i + 1), 32'h5000 + i, 0, 0, 0);
        idle(3);
        chk(match_cnt == 22, "R7 drain", match_cnt, 22);

        // R4 data mismatch, then R5 frozen
        step(1, 2, 32'h22, 1, 2, 32'h22);
        step(1, 3, 32'hAAAA, 1, 3, 32'hAAAB);
        idle(3);
        chk(mismatch && halt && fail_seq == 23, "R4 data mismatch seq", fail_seq, 23);
        chk(fail_ref_data == 32'hAAAA && fail_dut_data == 32'hAAAB, "R4 data capture", fail_dut_data, 32'hAAAB);
        for (int i = 0; i < 4; i++) step(1, 6, 32'h6, 1, 6, 32'h6);
        step(1, 7, 32'h1, 1, 8, 32'h2);
        idle(3);
        chk(match_cnt == 23 && fail_ref_idx == 3 && fail_dut_idx == 3, "R5 frozen after halt", match_cnt, 23);

        // R8
        do_reset();
        @(negedge clk);
        chk(!halt && !mismatch && match_cnt == 0, "R8 reset clears", match_cnt, 0);

        // R4 index mismatch at position 0
        step(1, 4, 32'h77, 1, 5, 32'h77);
        idle(3);
        chk(mismatch && fail_seq == 0 && fail_ref_idx == 4 && fail_dut_idx == 5, "R4 idx mismatch", 32'(fail_dut_idx), 5);
        do_reset();

        // R6 plain overflow
        for (int i = 0; i < D + 1; i++) step(1, 5'(i + 1), 32'h900 + i, 0, 0, 0);
        idle(2);
        chk(overflow && halt && !mismatch, "R6 overflow", 32'(overflow), 1);
        do_reset();

        // R6 overflow wins over a same-edge mismatch
        for (int i = 0; i < D; i++) step(1, 1, 32'h11, 0, 0, 0);
        step(0, 0, 0, 1, 2, 32'h22);
        step(1, 1, 32'h11, 0, 0, 0);
        idle(2);
        chk(overflow && !mismatch, "R6 precedence", {30'd0, overflow, mismatch}, 2);
        do_reset();
        idle(2);

        finish_run();
    end
endmodule